// File: doc/BRIEF.md
# Dual-Output Prioritizing Interrupt Controller

This block gathers interrupt requests from three kinds of source and picks a winner for each of two processor-facing lines. The sources are 16 software-triggered bits, 16 private level inputs and a parameterised number of shared level inputs. Each source is programmed with four settings: a 4-bit priority, a steering bit that sends it to the fast line or the normal line, an enable, and a secure flag.

Two arbiters run side by side. Each arbiter sees only the sources steered to it. It takes the pending, enabled, not-yet-active source with the smallest priority value, and a lower ID breaks any tie. The result is held in a register and drives an active-low output.

Software works the block through a single-cycle register port. It reads an acknowledge address to claim the current winner, and it writes the claimed ID to an end-of-interrupt address once the handler is done. While a claim is open on an output, only a strictly more urgent source can raise that output again.

Top module: `icx_intc`

## Requirements
- R1: After reset both outputs are high, every source is disabled with all of its configuration fields at zero, no software bit is pending and no source is active.
- R2: Shared and private inputs are level-sensitive. A source is pending only while its input is high. When the input drops, the output falls back without any acknowledge.
- R3: Among eligible sources on one output, the smaller priority value wins, and equal values go to the smaller ID. IDs 0–15 are software sources, 16–31 are private inputs 0–15, and 32 upward are shared inputs 0 upward.
- R4: Configuration bit 4 set steers a source to the fast output `fiq_n`, and clear steers it to the normal output `irq_n`. The two arbiters never affect each other.
- R5: An output goes low in the cycle after the first clock edge at which an eligible source is present. It goes high in the cycle after the first edge at which none is present.
- R6: A read of address NL (normal) or NL+1 (fast) returns the registered winner ID and marks that source active. With no winner it returns all ones in the ID width (127 by default) and has no effect.
- R7: An active source is not eligible again. On an output with active sources, only a source whose priority value is strictly below the smallest active value on that output is eligible.
- R8: A write of an ID in bits 6:0 to address NL+2 (normal) or NL+3 (fast) clears that source's active state.
- R9: A write to address NL+4 sets the software-source bits given by a one in wdata bits 15:0. A bit is cleared when its source is acknowledged. Zeros in the write have no effect.
- R10: Configuration addresses 0..NL-1 hold priority in bits 3:0, steering in bit 4, enable in bit 5 and secure in bit 6. A non-secure write to a secure source is ignored, and a non-secure read of one returns 0. A non-secure write cannot set bit 6.
- R11: A disabled source never wins and never drives an output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_irq | input | 16 | Private level request lines |
| shared_irq | input | N_SPI | Shared level request lines |
| reg_en | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_secure | input | 1 | Access carries secure privilege |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid in the access cycle |
| irq_n | output | 1 | Normal interrupt, active low |
| fiq_n | output | 1 | Fast interrupt, active low |

## Verification
The assertions assume that at most one access occurs per cycle and that reads and writes of the acknowledge and end-of-interrupt addresses follow the protocol. In particular, an end-of-interrupt write names an ID below NL, and an acknowledge is only counted as a claim while its output is low. The bench keeps every access to a single cycle. Its random phase only writes in-range IDs and source numbers, and it drives level inputs between clock edges. The reference model mirrors the one-cycle registered arbitration, so a claim or a dropped input still shows the old winner for exactly one cycle.

// File: rtl/icx_pkg.sv
package icx_pkg;
   localparam int N_SWI  = 16;
   localparam int N_PRIV = 16;
   localparam int PRIO_W = 4;

   typedef struct packed {
      logic                sec;
      logic                en;
      logic                fast;
      logic [PRIO_W-1:0]   prio;
   } line_cfg_t;

   localparam int CFG_W = $bits(line_cfg_t);
endpackage

// File: rtl/icx_cfg_regs.sv
module icx_cfg_regs #(
   parameter int NL = 64,
   parameter int AW = 7,
   parameter int DW = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic                            secure,
   input  logic [AW-1:0]                   addr,
   input  logic [DW-1:0]                   wdata,
   output icx_pkg::line_cfg_t [NL-1:0]     cfg,
   output logic [DW-1:0]                   rd_data
);
   import icx_pkg::*;

   logic unused_bits;
   assign unused_bits = ^wdata[DW-1:CFG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NL; i++) begin
            if (addr == AW'(i) && (!cfg[i].sec || secure)) begin
               cfg[i].prio <= wdata[PRIO_W-1:0];
               cfg[i].fast <= wdata[PRIO_W];
               cfg[i].en   <= wdata[PRIO_W+1];
               cfg[i].sec  <= secure & wdata[PRIO_W+2];
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NL; i++) begin
         if (addr == AW'(i) && (!cfg[i].sec || secure))
            rd_data[CFG_W-1:0] = cfg[i];
      end
   end
endmodule

// File: rtl/icx_arbiter.sv
module icx_arbiter #(
   parameter int NL       = 64,
   parameter int IDW      = 7,
   parameter bit SEL_FAST = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NL-1:0]                 pend,
   input  logic [NL-1:0]                 active,
   input  icx_pkg::line_cfg_t [NL-1:0]   cfg,
   output logic                          best_v,
   output logic [IDW-1:0]                best_id
);
   import icx_pkg::*;

   logic [PRIO_W:0]  run_p;
   logic [PRIO_W:0]  cand_p;
   logic             cand_v;
   logic [IDW-1:0]   cand_id;
   logic             unused_bits;

   always_comb begin
      unused_bits = 1'b0;
      for (int i = 0; i < NL; i++) unused_bits = unused_bits ^ cfg[i].sec;
   end

   // running priority: most urgent open claim on this output
   always_comb begin
      run_p = {1'b1, {PRIO_W{1'b0}}};
      for (int i = 0; i < NL; i++) begin
         if (active[i] && cfg[i].fast == SEL_FAST && {1'b0, cfg[i].prio} < run_p)
            run_p = {1'b0, cfg[i].prio};
      end
   end

   // strict less-than in ascending order keeps the lowest ID on ties
   always_comb begin
      cand_p  = run_p;
      cand_v  = 1'b0;
      cand_id = '0;
      for (int i = 0; i < NL; i++) begin
         if (pend[i] && cfg[i].en && !active[i] && cfg[i].fast == SEL_FAST &&
             {1'b0, cfg[i].prio} < cand_p) begin
            cand_p  = {1'b0, cfg[i].prio};
            cand_v  = 1'b1;
            cand_id = IDW'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_v  <= 1'b0;
         best_id <= '1;
      end else begin
         best_v  <= cand_v;
         best_id <= cand_v ? cand_id : '1;
      end
   end
endmodule

// File: rtl/icx_intc.sv
module icx_intc #(
   parameter  int N_SPI = 32,
   parameter  int DW    = 16,
   localparam int NL    = icx_pkg::N_SWI + icx_pkg::N_PRIV + N_SPI,
   localparam int IDW   = $clog2(NL) + 1,
   localparam int AW    = $clog2(NL + 5)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [icx_pkg::N_PRIV-1:0]    priv_irq,
   input  logic [N_SPI-1:0]              shared_irq,
   input  logic                          reg_en,
   input  logic                          reg_wr,
   input  logic                          reg_secure,
   input  logic [AW-1:0]                 reg_addr,
   input  logic [DW-1:0]                 reg_wdata,
   output logic [DW-1:0]                 reg_rdata,
   output logic                          irq_n,
   output logic                          fiq_n
);
   import icx_pkg::*;

   localparam logic [AW-1:0] A_ACK0 = AW'(NL);
   localparam logic [AW-1:0] A_EOI0 = AW'(NL + 2);
   localparam logic [AW-1:0] A_SWI  = AW'(NL + 4);

   if (N_SPI < 1 || DW < N_SWI || DW < IDW || DW < CFG_W) begin : g_bad_param
      $error("icx_intc: illegal parameter set");
   end

   line_cfg_t [NL-1:0]  cfg;
   logic [DW-1:0]       cfg_rd;
   logic [N_SWI-1:0]    soft_q;
   logic [NL-1:0]       act_q;
   logic [NL-1:0]       act_nxt;
   logic [NL-1:0]       pend;
   logic [1:0]          win_v;
   logic [IDW-1:0]      win_id [2];
   logic [1:0]          ack;
   logic                rd_op, wr_op;

   assign rd_op = reg_en & ~reg_wr;
   assign wr_op = reg_en &  reg_wr;
   assign pend  = {shared_irq, priv_irq, soft_q};

   icx_cfg_regs #(.NL(NL), .AW(AW), .DW(DW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_op), .secure(reg_secure),
      .addr(reg_addr), .wdata(reg_wdata), .cfg(cfg), .rd_data(cfg_rd)
   );

   for (genvar o = 0; o < 2; o++) begin : g_out
      icx_arbiter #(.NL(NL), .IDW(IDW), .SEL_FAST(o == 1)) u_arb (
         .clk(clk), .rst_n(rst_n), .pend(pend), .active(act_q), .cfg(cfg),
         .best_v(win_v[o]), .best_id(win_id[o])
      );
      assign ack[o] = rd_op && reg_addr == A_ACK0 + AW'(o) && win_v[o];
   end

   always_comb begin
      act_nxt = act_q;
      for (int o = 0; o < 2; o++) begin
         for (int i = 0; i < NL; i++) begin
            if (ack[o] && win_id[o] == IDW'(i))
               act_nxt[i] = 1'b1;
            if (wr_op && reg_addr == A_EOI0 + AW'(o) && reg_wdata[IDW-1:0] == IDW'(i))
               act_nxt[i] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         soft_q <= '0;
      end else begin
         act_q <= act_nxt;
         if (wr_op && reg_addr == A_SWI)
            soft_q <= soft_q | reg_wdata[N_SWI-1:0];
         for (int o = 0; o < 2; o++) begin
            for (int i = 0; i < N_SWI; i++) begin
               if (ack[o] && win_id[o] == IDW'(i))
                  soft_q[i] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      reg_rdata = cfg_rd;
      if (reg_addr == A_ACK0)               reg_rdata = DW'(win_id[0]);
      else if (reg_addr == A_ACK0 + AW'(1)) reg_rdata = DW'(win_id[1]);
   end

   assign irq_n = ~win_v[0];
   assign fiq_n = ~win_v[1];
endmodule

// File: rtl/icx_checks.sv
module icx_checks #(
   parameter  int N_SPI = 32,
   parameter  int DW    = 16,
   localparam int NL    = icx_pkg::N_SWI + icx_pkg::N_PRIV + N_SPI,
   localparam int IDW   = $clog2(NL) + 1,
   localparam int AW    = $clog2(NL + 5)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_en,
   input logic                          reg_wr,
   input logic                          reg_secure,
   input logic [AW-1:0]                 reg_addr,
   input logic [DW-1:0]                 reg_wdata,
   input logic [DW-1:0]                 reg_rdata,
   input logic                          irq_n,
   input logic                          fiq_n,
   input logic [icx_pkg::N_SWI-1:0]     soft_q,
   input logic [NL-1:0]                 act_q,
   input icx_pkg::line_cfg_t [NL-1:0]   cfg
);
   import icx_pkg::*;

   localparam logic [DW-1:0] SPUR = DW'({IDW{1'b1}});

   logic           rd, wr, sec_hit, in_cfg, act_at;
   logic [IDW-1:0] cap_q;
   logic [NL-1:0]  sec_vec;

   assign rd     = reg_en & ~reg_wr;
   assign wr     = reg_en &  reg_wr;
   assign in_cfg = reg_addr < AW'(NL);

   always_comb begin
      sec_hit = 1'b0;
      act_at  = 1'b0;
      for (int i = 0; i < NL; i++) begin
         sec_vec[i] = cfg[i].sec;
         if (reg_addr == AW'(i)) sec_hit = cfg[i].sec;
         if (cap_q == IDW'(i))   act_at  = act_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= '1;
      else        cap_q <= reg_wr ? reg_wdata[IDW-1:0] : reg_rdata[IDW-1:0];
   end

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_n && fiq_n));

   a_r6_spurious_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && reg_addr == AW'(NL) && irq_n) |-> reg_rdata == SPUR);

   a_r6_spurious_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && reg_addr == AW'(NL + 1) && fiq_n) |-> reg_rdata == SPUR);

   a_r6_ack_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && ((reg_addr == AW'(NL) && !irq_n) || (reg_addr == AW'(NL + 1) && !fiq_n)))
      |=> act_at);

   a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (reg_addr == AW'(NL + 2) || reg_addr == AW'(NL + 3)) &&
       reg_wdata[IDW-1:0] < IDW'(NL)) |=> !act_at);

   a_r9_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == AW'(NL + 4)) |=>
      ((soft_q & $past(reg_wdata[N_SWI-1:0])) == $past(reg_wdata[N_SWI-1:0])));

   a_r10_secure_read_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && in_cfg && !reg_secure && sec_hit) |-> reg_rdata == '0);

   a_r10_secure_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && in_cfg && !reg_secure && sec_hit) |=> cfg == $past(cfg));

   a_r10_no_secure_promotion: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !reg_secure) |=> $countones(sec_vec) <= $past($countones(sec_vec)));
endmodule

bind icx_intc icx_checks #(.N_SPI(N_SPI), .DW(DW)) u_chk (.*);

// File: tb/tb_icx_intc.sv
module tb_icx_intc;
   localparam int N_SPI = 32;
   localparam int DW    = 16;
   localparam int NL    = 64;
   localparam int AW    = 7;
   localparam int SPUR  = 127;
   localparam int A_ACK_N = NL, A_ACK_F = NL + 1, A_EOI_N = NL + 2, A_EOI_F = NL + 3, A_SWI = NL + 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [15:0] priv_irq = '0;
   logic [N_SPI-1:0] shared_irq = '0;
   logic reg_en = 0, reg_wr = 0, reg_secure = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic irq_n, fiq_n;

   always #2 clk = ~clk;

   icx_intc #(.N_SPI(N_SPI), .DW(DW)) dut (.*);

   int checks = 0, fails = 0;
   int m_prio[NL];
   bit m_fast[NL], m_en[NL], m_sec[NL], m_act[NL];
   bit [15:0] m_soft;
   bit m_bv[2];
   int m_bid[2];

   function automatic bit m_pend(int i);
      if (i < 16) return m_soft[i];
      if (i < 32) return priv_irq[i-16];
      return shared_irq[i-32];
   endfunction

   function automatic int m_read(int a, bit s);
      if (a < NL) begin
         if (m_sec[a] && !s) return 0;
         return (int'(m_sec[a]) << 6) | (int'(m_en[a]) << 5) | (int'(m_fast[a]) << 4) | m_prio[a];
      end
      if (a == A_ACK_N) return m_bv[0] ? m_bid[0] : SPUR;
      if (a == A_ACK_F) return m_bv[1] ? m_bid[1] : SPUR;
      return 0;
   endfunction

   task automatic check(int act, int exp, string req);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge(bit en, bit wr, bit s, int a, int wd);
      bit nv[2];
      int nid[2];
      for (int o = 0; o < 2; o++) begin
         int run = 16, best = 16;
         nv[o] = 0; nid[o] = SPUR;
         for (int i = 0; i < NL; i++)
            if (m_act[i] && m_fast[i] == (o == 1) && m_prio[i] < run) run = m_prio[i];
         best = run;
         for (int i = 0; i < NL; i++)
            if (m_pend(i) && m_en[i] && !m_act[i] && m_fast[i] == (o == 1) && m_prio[i] < best) begin
               best = m_prio[i]; nv[o] = 1; nid[o] = i;
            end
      end
      if (en && wr && a < NL && (!m_sec[a] || s)) begin
         m_prio[a] = wd & 15; m_fast[a] = wd[4]; m_en[a] = wd[5]; m_sec[a] = s & wd[6];
      end
      if (en && !wr && (a == A_ACK_N || a == A_ACK_F)) begin
         int o = a - A_ACK_N;
         if (m_bv[o]) begin
            m_act[m_bid[o]] = 1;
            if (m_bid[o] < 16) m_soft[m_bid[o]] = 0;
         end
      end
      if (en && wr && (a == A_EOI_N || a == A_EOI_F) && (wd & 127) < NL) m_act[wd & 127] = 0;
      if (en && wr && a == A_SWI) m_soft = m_soft | 16'(wd);
      m_bv = nv; m_bid = nid;
   endtask

   // one cycle: drive at the falling edge, read data before the rising edge,
   // outputs compared after it
   task automatic step(bit en, bit wr, bit s, int a, int wd, string req, bit chk_rd);
      reg_en = en; reg_wr = wr; reg_secure = s; reg_addr = AW'(a); reg_wdata = DW'(wd);
      #1;
      if (chk_rd) check(int'(reg_rdata), m_read(a, s), req);
      @(posedge clk);
      model_edge(en, wr, s, a, wd);
      #1;
      check({30'd0, irq_n, fiq_n}, {30'd0, !m_bv[0], !m_bv[1]}, req);
      #1;
      reg_en = 0; reg_wr = 0;
   endtask

   task automatic idle(int n, string req);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, req, 0);
   endtask

   task automatic cfg_line(int id, int p, bit f, bit e, bit sc, bit s, string req);
      step(1, 1, s, id, (int'(sc) << 6) | (int'(e) << 5) | (int'(f) << 4) | p, req, 0);
   endtask

   task automatic rd(int a, bit s, string req);
      step(1, 0, s, a, 0, req, 1);
   endtask

   task automatic wr(int a, int wd, string req);
      step(1, 1, 1, a, wd, req, 0);
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) begin
         m_prio[i] = 0; m_fast[i] = 0; m_en[i] = 0; m_sec[i] = 0; m_act[i] = 0;
      end
      m_soft = 0; m_bv = '{0, 0}; m_bid = '{SPUR, SPUR};
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: reset state
      check({30'd0, irq_n, fiq_n}, 3, "R1");
      rd(A_ACK_N, 1, "R1"); rd(A_ACK_F, 1, "R1"); rd(40, 1, "R1");
      // R11: disabled line ignored
      shared_irq[0] = 1;
      cfg_line(32, 5, 0, 0, 0, 1, "R11"); idle(3, "R11"); rd(A_ACK_N, 1, "R11");
      // R5 timing, R2 level release
      cfg_line(32, 5, 0, 1, 0, 1, "R5"); idle(2, "R5");
      check(int'(irq_n), 0, "R5");
      shared_irq[0] = 0; idle(3, "R2");
      check(int'(irq_n), 1, "R2");
      // R3: priority and ties
      cfg_line(33, 3, 0, 1, 0, 1, "R3"); cfg_line(34, 3, 0, 1, 0, 1, "R3");
      cfg_line(40, 1, 0, 1, 0, 1, "R3");
      shared_irq[1] = 1; shared_irq[2] = 1; idle(2, "R3");
      rd(A_ACK_N, 1, "R3"); idle(2, "R7"); rd(A_ACK_N, 1, "R7");
      wr(A_EOI_N, 33, "R8");
      shared_irq[8] = 1; idle(2, "R3"); rd(A_ACK_N, 1, "R3");
      wr(A_EOI_N, 40, "R8");
      shared_irq = '0; idle(2, "R2");
      // R4: steering
      cfg_line(35, 7, 1, 1, 0, 1, "R4"); cfg_line(36, 2, 0, 1, 0, 1, "R4");
      shared_irq[3] = 1; shared_irq[4] = 1; idle(2, "R4");
      rd(A_ACK_F, 1, "R4"); rd(A_ACK_N, 1, "R4");
      wr(A_EOI_F, 35, "R8"); wr(A_EOI_N, 36, "R8");
      shared_irq = '0; idle(2, "R4");
      // R7: preemption only by strictly more urgent
      shared_irq[8] = 1; idle(2, "R7"); rd(A_ACK_N, 1, "R7");
      shared_irq[1] = 1; idle(3, "R7");
      check(int'(irq_n), 1, "R7");
      cfg_line(41, 0, 0, 1, 0, 1, "R7"); shared_irq[9] = 1; idle(2, "R7");
      rd(A_ACK_N, 1, "R7");
      wr(A_EOI_N, 41, "R8"); wr(A_EOI_N, 40, "R8"); idle(2, "R8"); rd(A_ACK_N, 1, "R8");
      shared_irq = '0; wr(A_EOI_N, 40, "R8"); idle(2, "R8");
      // R9: software sources
      cfg_line(2, 2, 0, 1, 0, 1, "R9"); cfg_line(5, 2, 0, 1, 0, 1, "R9");
      wr(A_SWI, 16'h0024, "R9"); idle(2, "R9"); rd(A_ACK_N, 1, "R9");
      wr(A_EOI_N, 2, "R9"); idle(2, "R9"); rd(A_ACK_N, 1, "R9");
      wr(A_EOI_N, 5, "R9"); idle(2, "R6"); rd(A_ACK_N, 1, "R6");
      // private line on the fast output
      priv_irq[3] = 1; cfg_line(19, 4, 1, 1, 0, 1, "R2"); idle(2, "R2");
      rd(A_ACK_F, 1, "R2"); wr(A_EOI_F, 19, "R8"); priv_irq = '0; idle(2, "R2");
      // R10: secure flag
      cfg_line(50, 6, 0, 1, 1, 1, "R10");
      rd(50, 0, "R10"); rd(50, 1, "R10");
      cfg_line(50, 1, 1, 0, 0, 0, "R10"); rd(50, 1, "R10");
      cfg_line(51, 3, 0, 1, 1, 0, "R10"); rd(51, 1, "R10");
      shared_irq[18] = 1; idle(2, "R10"); rd(A_ACK_N, 1, "R10");
      wr(A_EOI_N, 50, "R10"); shared_irq = '0; idle(2, "R10");
      // mixed traffic against the model
      for (int k = 0; k < 400; k++) begin
         int op = $urandom % 7;
         shared_irq = N_SPI'($urandom);
         priv_irq = 16'($urandom);
         case (op)
            0, 6: idle(1, "R3");
            1: cfg_line($urandom % NL, $urandom % 16, $urandom % 2, $urandom % 2, 0, 1, "R4");
            2: rd(A_ACK_N, 1, "R3");
            3: rd(A_ACK_F, 1, "R4");
            4: wr(($urandom % 2) ? A_EOI_N : A_EOI_F, $urandom % NL, "R8");
            default: wr(A_SWI, $urandom % 65536, "R9");
         endcase
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule